// File: doc/BRIEF.md
# Indirect Coefficient Memory Access Bridge

This block sits between a byte-wide register bus and a single-port synchronous coefficient memory of 161 words, each 24 bits wide. Software never addresses the memory directly. It loads a word index into the index register, places the low and middle bytes of the word in two staging registers, and then writes the top byte. That last write commits the assembled word to the memory. A busy flag stays set while the internal cycle runs, and the index steps forward by one when the write finishes, so a table of coefficients can be streamed with no further index writes.

Reading works the same way. Loading the index fetches that word into three read-back byte registers. Reading the top read-back byte returns its value, advances the index and fetches the next word. Indices from 161 to 255 reach no memory cell: commits to them are discarded and fetches from them return zero. The index still steps past them and wraps from 255 to 0. A guarded access that arrives while the busy flag is set is discarded and recorded in a sticky error flag.

The sequencer has four states. `ST_IDLE` waits for a start. A top-byte commit moves it to `ST_WRITE`, which counts down `WR_CYCLES` cycles, writes the memory in its last cycle and returns to `ST_IDLE`. An index write or a top read-back read moves it to `ST_FETCH_REQ`, which issues the memory read. `ST_FETCH_CAP` follows unconditionally, latches the word into the read-back bytes and returns to `ST_IDLE`. When a commit and a fetch are requested in the same cycle, the commit wins.

Top module: `coef_ram_bridge`

## Requirements
- R1: Every index 0 to 160 stores a full 24-bit word, and a later fetch of that index returns the same word.
- R2: Register select 0 is the index register. It is read/write and holds a word index, not a byte address.
- R3: Select 1 stages word bits 7:0, select 2 stages bits 15:8 and select 3 carries bits 23:16. The read-back bytes at selects 6, 7 and 8 return bits 7:0, 15:8 and 23:16 of the fetched word. Reading a staging select returns the staged byte.
- R4: Writes to selects 1 and 2 only stage bytes. They set no busy flag, change no memory word and leave the index unchanged.
- R5: Select 4 is the flag register. Bit 7 reads 1 while a memory write or fetch is in progress, and bits 6:0 read 0.
- R6: When a commit's write cycle completes, the index increments by one.
- R7: A read of select 8 increments the index and fetches the word at the new index into selects 6 to 8.
- R8: After reset the index, the flag register, the error flag and all staging and read-back bytes read 0.
- R9: After a write to select 3, the busy flag stays set for exactly `WR_CYCLES` cycles (default 8).
- R10: A write to select 0 fetches the addressed word. Busy stays set for exactly 2 cycles.
- R11: Indices 161 to 255 leave the memory untouched, and fetches from them return 0. The index still increments, and it wraps from 255 to 0.
- R12: While busy, writes to selects 0 to 3 and reads of select 8 are discarded. Each sets bit 0 of select 5, a sticky error flag. Any write to select 5 clears that flag.
- R13: Register read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read. Unmapped selects read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_sel | input | 4 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, and that `bus_sel` and `bus_wdata` are steady while a strobe is high. The bench meets both conditions. Each access task raises exactly one strobe at a falling edge and drops it at the next falling edge. The bench also waits out each busy window before the next guarded access, except in the scenario that deliberately collides with the busy window to exercise the drop-and-flag behaviour.

// File: rtl/coef_bridge_pkg.sv
package coef_bridge_pkg;
    localparam int LANES  = 3;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int SEL_W  = 4;

    // Register selects; the staging and read-back lanes run upward from their base.
    localparam logic [SEL_W-1:0] SEL_ENTRY = 4'd0;
    localparam logic [SEL_W-1:0] SEL_STG0  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_FLAGS = 4'd4;
    localparam logic [SEL_W-1:0] SEL_ERR   = 4'd5;
    localparam logic [SEL_W-1:0] SEL_RD0   = 4'd6;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_FETCH_REQ,
        ST_FETCH_CAP
    } seq_state_e;
endpackage

// File: rtl/coef_ram_array.sv
module coef_ram_array
    import coef_bridge_pkg::*;
#(
    parameter int DEPTH  = 161,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_we,
    input  logic              mem_re,
    input  logic [ADDR_W-1:0] mem_addr,
    input  word_t             mem_wdata,
    output word_t             mem_q
);
    localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (mem_we) begin
            store[mem_addr] <= mem_wdata;
        end
        if (mem_re) begin
            mem_q <= store[mem_addr];
        end
    end

    // R11
    mem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> ({1'b0, mem_addr} < DEPTH_V));

    // R1
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
endmodule

// File: rtl/coef_seq_fsm.sv
module coef_seq_fsm
    import coef_bridge_pkg::*;
#(
    parameter int DEPTH     = 161,
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_fetch,
    input  logic [ADDR_W-1:0] entry_addr,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_re,
    output logic              wr_done,
    output logic              fetch_cap,
    output logic              cap_valid
);
    localparam int              CNT_W   = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WR_CYCLES - 1);
    localparam logic [ADDR_W:0]  DEPTH_V = (ADDR_W+1)'(DEPTH);

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             addr_ok;
    logic             ok_q;

    assign addr_ok = ({1'b0, entry_addr} < DEPTH_V);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ok_q  <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (state == ST_FETCH_REQ) begin
                ok_q <= addr_ok;
            end
        end
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start_wr) begin
                    state_nx = ST_WRITE;
                    cnt_nx   = CNT_TOP;
                end else if (start_fetch) begin
                    state_nx = ST_FETCH_REQ;
                end
            end
            ST_WRITE: begin
                if (cnt == '0) begin
                    state_nx = ST_IDLE;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_FETCH_REQ: state_nx = ST_FETCH_CAP;
            ST_FETCH_CAP: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        busy      = (state != ST_IDLE);
        wr_done   = (state == ST_WRITE) && (cnt == '0);
        mem_we    = (state == ST_WRITE) && (cnt == '0) && addr_ok;
        mem_re    = (state == ST_FETCH_REQ) && addr_ok;
        fetch_cap = (state == ST_FETCH_CAP);
        cap_valid = ok_q;
    end

    // R9
    wr_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_wr) |=> (state == ST_WRITE && cnt == CNT_TOP));

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && cnt != '0) |=> (state == ST_WRITE && cnt == $past(cnt) - 1'b1));

    // R10
    fetch_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_REQ) |=> (state == ST_FETCH_CAP));

    // R10
    fetch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_CAP) |=> (state == ST_IDLE));
endmodule

// File: rtl/coef_bus_regs.sv
module coef_bus_regs
    import coef_bridge_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              wr_done,
    input  logic              fetch_cap,
    input  logic              cap_valid,
    input  word_t             mem_q,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] entry_addr,
    output word_t             stage_word,
    output logic              start_wr,
    output logic              start_fetch
);
    localparam logic [SEL_W-1:0] SEL_RDHI = SEL_W'(SEL_RD0 + LANES - 1);

    logic [LANES-1:0][BYTE_W-1:0] stage_q;
    logic [LANES-1:0][BYTE_W-1:0] rdb_q;
    logic [LANES-1:0]             stg_hit;
    logic [ADDR_W-1:0]            entry_q;
    logic                         err_q;
    logic                         entry_hit, rdhi_hit, err_hit, guarded, drop;
    logic [BYTE_W-1:0]            rd_mux;

    for (genvar l = 0; l < LANES; l++) begin : g_dec
        assign stg_hit[l] = bus_wr && (bus_sel == SEL_W'(SEL_STG0 + l));
    end

    assign entry_hit   = bus_wr && (bus_sel == SEL_ENTRY);
    assign err_hit     = bus_wr && (bus_sel == SEL_ERR);
    assign rdhi_hit    = bus_rd && (bus_sel == SEL_RDHI);
    assign guarded     = entry_hit || (|stg_hit) || rdhi_hit;
    assign drop        = guarded && busy;
    assign start_wr    = stg_hit[LANES-1] && !busy;
    assign start_fetch = (entry_hit || rdhi_hit) && !busy;
    assign entry_addr  = entry_q;
    assign stage_word  = stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else if (entry_hit && !busy) begin
            entry_q <= ADDR_W'(bus_wdata);
        end else if ((rdhi_hit && !busy) || wr_done) begin
            entry_q <= entry_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            rdb_q   <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (stg_hit[l] && !busy) begin
                    stage_q[l] <= bus_wdata;
                end
                if (fetch_cap) begin
                    rdb_q[l] <= cap_valid ? mem_q[l*BYTE_W +: BYTE_W] : '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_hit) begin
            err_q <= 1'b0;
        end else if (drop) begin
            err_q <= 1'b1;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_sel == SEL_ENTRY) rd_mux = BYTE_W'(entry_q);
        if (bus_sel == SEL_FLAGS) rd_mux = {busy, 7'd0};
        if (bus_sel == SEL_ERR)   rd_mux = {7'd0, err_q};
        for (int l = 0; l < LANES; l++) begin
            if (bus_sel == SEL_W'(SEL_STG0 + l)) rd_mux = stage_q[l];
            if (bus_sel == SEL_W'(SEL_RD0 + l))  rd_mux = rdb_q[l];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // R5
    flags_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == SEL_FLAGS) |=> (bus_rdata[6:0] == 7'd0));

    // R6
    entry_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (entry_q == $past(entry_q) + 1'b1));

    // R12
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> (stage_q == $past(stage_q)));

    // R12
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && guarded) |=> err_q);

    // R4
    stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && !bus_rd && (bus_sel == SEL_STG0 || bus_sel == SEL_W'(SEL_STG0 + 1)))
        |=> (!busy && entry_q == $past(entry_q)));

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/coef_ram_bridge.sv
module coef_ram_bridge
    import coef_bridge_pkg::*;
#(
    parameter int DEPTH     = 161,
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [3:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    logic              busy, mem_we, mem_re, wr_done, fetch_cap, cap_valid;
    logic              start_wr, start_fetch;
    logic [ADDR_W-1:0] entry_addr;
    word_t             stage_word, mem_q;

    coef_bus_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_sel     (bus_sel),
        .bus_wdata   (bus_wdata),
        .busy        (busy),
        .wr_done     (wr_done),
        .fetch_cap   (fetch_cap),
        .cap_valid   (cap_valid),
        .mem_q       (mem_q),
        .bus_rdata   (bus_rdata),
        .entry_addr  (entry_addr),
        .stage_word  (stage_word),
        .start_wr    (start_wr),
        .start_fetch (start_fetch)
    );

    coef_seq_fsm #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start_wr),
        .start_fetch (start_fetch),
        .entry_addr  (entry_addr),
        .busy        (busy),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .wr_done     (wr_done),
        .fetch_cap   (fetch_cap),
        .cap_valid   (cap_valid)
    );

    coef_ram_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (entry_addr),
        .mem_wdata (stage_word),
        .mem_q     (mem_q)
    );
endmodule

// File: tb/tb_coef_ram_bridge.sv
module tb_coef_ram_bridge;
    localparam int WR    = 8;
    localparam int DEPTH = 161;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_sel = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    coef_ram_bridge #(.DEPTH(DEPTH), .ADDR_W(8), .WR_CYCLES(WR)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #2 clk = ~clk;

    function automatic logic [23:0] pat(input int i);
        logic [31:0] t;
        t = (32'(i) * 32'h000B3C5D) ^ 32'h00A5C3E1;
        return t[23:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called right after a strobe: holds flag reads and counts busy samples.
    task automatic busy_count(output int ones, output int resv_bad);
        ones = 0; resv_bad = 0;
        bus_sel = 4'd4; bus_rd = 1'b1;
        for (int k = 1; k <= WR + 3; k++) begin
            @(negedge clk);
            if (bus_rdata[7]) ones++;
            if (bus_rdata[6:0] != 7'd0) resv_bad++;
        end
        bus_rd = 1'b0;
    endtask

    task automatic fetch_word(input int idx, output logic [23:0] w);
        logic [7:0] b0, b1, b2;
        wr(4'd0, 8'(idx));
        idle(3);
        rd(4'd6, b0); rd(4'd7, b1); rd(4'd8, b2);
        idle(3);
        w = {b2, b1, b0};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual expired expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [23:0] w;
        int ones, bad;

        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R8 reset values
        rd(4'd0, v); chk("R8 index", v, 0);
        rd(4'd4, v); chk("R8 flags", v, 0);
        rd(4'd5, v); chk("R8 error", v, 0);
        rd(4'd6, v); chk("R8 readback", v, 0);
        rd(4'd1, v); chk("R8 stage", v, 0);
        // R13 unmapped select
        rd(4'd15, v); chk("R13 unmapped", v, 0);

        // R2 index register holds a word index
        wr(4'd0, 8'd77); idle(3);
        rd(4'd0, v); chk("R2 index readback", v, 77);

        // R10 fetch busy length
        wr(4'd0, 8'd0);
        busy_count(ones, bad);
        chk("R10 fetch busy cycles", ones, 2);

        // R1 R3 R6 R9 write sweep over all entries
        for (int i = 0; i < DEPTH; i++) begin
            w = pat(i);
            wr(4'd1, w[7:0]);
            wr(4'd2, w[15:8]);
            wr(4'd3, w[23:16]);
            if (i == 7) begin
                busy_count(ones, bad);
                chk("R9 write busy cycles", ones, WR);
                chk("R5 reserved flag bits", bad, 0);
            end else begin
                idle(WR + 2);
            end
        end
        rd(4'd0, v); chk("R6 index after sweep", v, DEPTH);

        // R1 R3 R7 read sweep
        wr(4'd0, 8'd0); idle(3);
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] b0, b1, b2;
            w = pat(i);
            rd(4'd6, b0); rd(4'd7, b1); rd(4'd8, b2);
            idle(3);
            chk("R1 R3 word", {8'd0, b2, b1, b0}, {8'd0, w});
        end
        rd(4'd0, v); chk("R7 index after read sweep", v, DEPTH);

        // R11 out-of-range index
        fetch_word(200, w); chk("R11 fetch out of range", w, 0);
        wr(4'd0, 8'd200); idle(3);
        wr(4'd1, 8'hFF); wr(4'd2, 8'hFF); wr(4'd3, 8'hFF); idle(WR + 2);
        rd(4'd0, v); chk("R11 index steps past range", v, 201);
        fetch_word(39, w); chk("R11 no alias 39", w, pat(39));
        fetch_word(72, w); chk("R11 no alias 72", w, pat(72));
        wr(4'd0, 8'd255); idle(3);
        wr(4'd3, 8'h12); idle(WR + 2);
        rd(4'd0, v); chk("R11 wrap after commit", v, 0);
        wr(4'd0, 8'd255); idle(3);
        rd(4'd8, v); chk("R11 readback out of range", v, 0);
        idle(3);
        rd(4'd0, v); chk("R11 wrap after read", v, 0);
        rd(4'd6, v); chk("R7 fetched entry 0", v, {24'd0, pat(0)} & 32'hFF);

        // R4 staging writes do not commit
        wr(4'd0, 8'd10); idle(3);
        wr(4'd1, 8'h11); wr(4'd2, 8'h22);
        rd(4'd4, v); chk("R4 no busy", v, 0);
        rd(4'd0, v); chk("R4 index unchanged", v, 10);
        fetch_word(10, w); chk("R4 memory unchanged", w, pat(10));

        // R12 dropped accesses while busy
        wr(4'd0, 8'd20); idle(3);
        wr(4'd1, 8'h3C); wr(4'd2, 8'h5A);
        wr(4'd3, 8'h96);
        wr(4'd1, 8'hEE);
        wr(4'd0, 8'd99);
        rd(4'd5, v); chk("R12 error set", v, 1);
        idle(WR);
        rd(4'd1, v); chk("R12 stage kept", v, 8'h3C);
        rd(4'd0, v); chk("R12 index kept", v, 21);
        fetch_word(20, w); chk("R12 committed word", w, 24'h965A3C);
        rd(4'd5, v); chk("R12 error sticky", v, 1);
        wr(4'd5, 8'h00);
        rd(4'd5, v); chk("R12 error cleared", v, 0);

        // R13 read data is registered: old value before the edge, new after
        @(negedge clk);
        bus_sel = 4'd0; bus_rd = 1'b1;
        #1 chk("R13 before edge", bus_rdata, 0);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R13 after edge", bus_rdata, 21);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule